// File: doc/BRIEF.md
# Split-width IOMMU configuration register file

This block holds the two 64-bit configuration words of an I/O address translator: a control word and a table base word. Their values are driven straight out to the translation walker. A bus slave port updates the words and reads them back. Each access is a single-cycle request that carries a byte offset, a write flag, a width flag (64-bit or 32-bit) and write data. After reset both words are zero, so translation starts switched off.

The halves follow a big-endian layout. A 32-bit access at a word's base offset reaches the upper half of that word. A 32-bit access at base+4 reaches the lower half. A 64-bit access at the base offset reaches the whole word. The word after the two configuration words is a flush location: it accepts accesses, does nothing and reads as zero. Every other offset is ignored. An access to one of those offsets raises a one-cycle strobe, so the rest of the system can see accesses that went nowhere.

Top module: `iommu_cfg_regs`

## Requirements
- R1: While reset is low at a clock edge, the control word, the base word and the read data are cleared to zero, and the unmapped strobe is cleared to 0.
- R2: A 64-bit access at offset 0x00 (control) or 0x08 (base) writes the whole word from wdata[63:0], or returns the whole word on a read.
- R3: A 32-bit write at offset 0x00 or 0x08 loads wdata[31:0] into bits 63:32 of that word and leaves bits 31:0 unchanged.
- R4: An access of either width at offset 0x04 or 0x0C reaches only bits 31:0 of the control or base word. A write loads them from wdata[31:0] and keeps bits 63:32. A read returns them in rd_data[31:0], with rd_data[63:32] zero.
- R5: A 32-bit read at offset 0x00 or 0x08 returns bits 63:32 of that word in rd_data[31:0], with rd_data[63:32] zero.
- R6: Accesses at offset 0x10 or 0x14, of either width, change no word, return zero on a read and do not raise the unmapped strobe.
- R7: An access at any other offset changes no word and returns zero on a read. Such offsets include offsets that are not multiples of 4, offsets 0x18 to 0x1F and offsets of 0x20 and above. The access raises unmapped_hit for exactly the one cycle after the access.
- R8: Read data appears in the cycle after the read access and holds until the next read. Writes appear on ctrl_q and base_q in the cycle after the write access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| acc_addr | input | ADDR_W (8) | Byte offset of the access |
| acc_wdata | input | DATA_W (64) | Write data; 32-bit writes use bits 31:0 |
| rd_data | output | DATA_W (64) | Registered read data |
| ctrl_q | output | DATA_W (64) | Current control word, to the walker |
| base_q | output | DATA_W (64) | Current table base word, to the walker |
| unmapped_hit | output | 1 | One-cycle strobe after an access to an ignored offset |

## Verification
The bench builds the block with its default ADDR_W of 8 and DATA_W of 64. With these values, every byte offset from 0x00 to 0xFF can be swept at both widths, as a write and then as a read. The sweep reaches each half of both words, the inert flush pair, misaligned offsets, the unused word inside the decoded window and every offset above that window. Expected word contents, read data and strobe values come from a bench model that classifies each offset arithmetically. Reset, the single-cycle strobe and read-data hold are checked separately.

// File: rtl/iommu_cfg_pkg.sv
// Package: shared access classification and layout constants for the
// translator configuration register file.
package iommu_cfg_pkg;

    // How one decoded access touches the register file.
    typedef enum logic [2:0] {
        ACC_NONE  = 3'd0,   // unmapped offset
        ACC_FULL  = 3'd1,   // whole 64-bit word
        ACC_UPPER = 3'd2,   // 32-bit access to bits 63:32
        ACC_LOWER = 3'd3,   // access to bits 31:0
        ACC_INERT = 3'd4    // flush pair: accepted, no effect
    } acc_kind_e;

    // Number of configuration words (control, table base).
    localparam int unsigned NUM_REGS = 2;
    // Bytes per configuration word.
    localparam int unsigned WORD_BYTES = 8;

endpackage

// File: rtl/iommu_cfg_decode.sv
// Module: iommu_cfg_decode
// Classifies a byte offset and width into an access kind and a word
// index. Assumes the words are WORD_BYTES apart from offset 0 and the
// inert flush word sits right after the last configuration word.
// Offsets that are not multiples of 4 are unmapped.
module iommu_cfg_decode
    import iommu_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    output acc_kind_e         kind,
    output logic [$clog2(NUM_REGS)-1:0] sel
);
    localparam int unsigned SEL_W  = $clog2(NUM_REGS);
    localparam int unsigned LSB_W  = $clog2(WORD_BYTES);
    localparam int unsigned WIN_W  = $clog2(WORD_BYTES * (NUM_REGS + 1));
    localparam int unsigned WORD_W = WIN_W - LSB_W;

    logic              in_window;
    logic [WORD_W-1:0] word_idx;

    // Offset must lie inside the decoded window.
    assign in_window = (addr[ADDR_W-1:WIN_W] == '0);
    assign word_idx  = addr[WIN_W-1:LSB_W];
    assign sel       = addr[LSB_W +: SEL_W];

    // Map word index, half select and width onto an access kind.
    always_comb begin
        kind = ACC_NONE;
        if (in_window && (addr[1:0] == 2'b00)) begin
            if (word_idx < WORD_W'(NUM_REGS)) begin
                if (addr[2])   kind = ACC_LOWER;
                else if (wide) kind = ACC_FULL;
                else           kind = ACC_UPPER;
            end else if (word_idx == WORD_W'(NUM_REGS)) begin
                kind = ACC_INERT;
            end
        end
    end

endmodule

// File: rtl/iommu_cfg_word.sv
// Module: iommu_cfg_word
// One configuration word with split-width write. A half write always
// takes its data from the low half of the write bus. Assumes wr_en is
// set only for accesses aimed at this word.
module iommu_cfg_word
    import iommu_cfg_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  acc_kind_e         kind,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    localparam int unsigned HALF_W = DATA_W / 2;

    // Update the whole word or one half, per access kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            case (kind)
                ACC_FULL:  q                 <= wdata;
                ACC_UPPER: q[DATA_W-1:HALF_W] <= wdata[HALF_W-1:0];
                ACC_LOWER: q[HALF_W-1:0]      <= wdata[HALF_W-1:0];
                default:   ;
            endcase
        end
    end

    // R2
    full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_FULL) |=> (q == $past(wdata)));

    // R3
    upper_write_keeps_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_UPPER) |=>
            (q[HALF_W-1:0] == $past(q[HALF_W-1:0]) &&
             q[DATA_W-1:HALF_W] == $past(wdata[HALF_W-1:0])));

    // R4
    lower_write_keeps_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == ACC_LOWER) |=>
            (q[DATA_W-1:HALF_W] == $past(q[DATA_W-1:HALF_W]) &&
             q[HALF_W-1:0] == $past(wdata[HALF_W-1:0])));

    // R7
    idle_word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (kind == ACC_FULL || kind == ACC_UPPER || kind == ACC_LOWER))
            |=> $stable(q));

endmodule

// File: rtl/iommu_cfg_rdmux.sv
// Module: iommu_cfg_rdmux
// Selects read data: the whole word, or one half placed in the low
// lanes with the upper lanes zero. Flush and unmapped kinds read zero.
// Assumes sel is below NUM_REGS whenever kind names a word half.
module iommu_cfg_rdmux
    import iommu_cfg_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] words,
    input  logic [$clog2(NUM_REGS)-1:0]     sel,
    input  acc_kind_e                       kind,
    output logic [DATA_W-1:0]               rd_val
);
    localparam int unsigned HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] picked;

    assign picked = words[sel];

    // Shape the picked word to the width and half of the access.
    always_comb begin
        case (kind)
            ACC_FULL:  rd_val = picked;
            ACC_UPPER: rd_val = {{HALF_W{1'b0}}, picked[DATA_W-1:HALF_W]};
            ACC_LOWER: rd_val = {{HALF_W{1'b0}}, picked[HALF_W-1:0]};
            default:   rd_val = '0;
        endcase
    end

endmodule

// File: rtl/iommu_cfg_regs.sv
// Module: iommu_cfg_regs
// Configuration register file of an I/O address translator: control
// and table base words behind a single-cycle slave port, with 32-bit
// half access in big-endian order and an inert flush pair. Assumes
// ADDR_W is wider than the decoded window.
module iommu_cfg_regs
    import iommu_cfg_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_wide,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] base_q,
    output logic              unmapped_hit
);
    localparam int unsigned SEL_W = $clog2(NUM_REGS);

    acc_kind_e                       kind;
    logic [SEL_W-1:0]                sel;
    logic [NUM_REGS-1:0][DATA_W-1:0] words;
    logic [DATA_W-1:0]               rd_val;
    logic                            rd_req;

    iommu_cfg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (acc_addr),
        .wide (acc_wide),
        .kind (kind),
        .sel  (sel)
    );

    // One word instance per configuration register.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
        logic wr_en;
        assign wr_en = acc_valid && acc_write && (sel == SEL_W'(i));
        iommu_cfg_word #(.DATA_W(DATA_W)) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_en),
            .kind  (kind),
            .wdata (acc_wdata),
            .q     (words[i])
        );
    end

    iommu_cfg_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .words  (words),
        .sel    (sel),
        .kind   (kind),
        .rd_val (rd_val)
    );

    assign rd_req = acc_valid && !acc_write;
    assign ctrl_q = words[0];
    assign base_q = words[1];

    // Capture read data on a read; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_req) rd_data <= rd_val;
    end

    // Flag an access that hit no mapped or inert offset.
    always_ff @(posedge clk) begin
        if (!rst_n) unmapped_hit <= 1'b0;
        else        unmapped_hit <= acc_valid && (kind == ACC_NONE);
    end

    // R6
    // R7
    zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && (kind == ACC_NONE || kind == ACC_INERT)) |=> (rd_data == '0));

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_data));

    // R7
    strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped_hit |-> $past(acc_valid));

    // R6
    inert_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && kind == ACC_INERT) |=> !unmapped_hit);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ctrl_q == '0 && base_q == '0 && rd_data == '0 && !unmapped_hit));

endmodule

// File: tb/iommu_cfg_regs_bench.sv
`timescale 1ns/1ps
module iommu_cfg_regs_bench;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              acc_valid = 1'b0;
    logic              acc_write = 1'b0;
    logic              acc_wide = 1'b0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [DATA_W-1:0] acc_wdata = '0;
    logic [DATA_W-1:0] rd_data, ctrl_q, base_q;
    logic              unmapped_hit;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] m_word [2];
    logic [63:0] m_rd;

    iommu_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_iommu_cfg_regs (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_wide(acc_wide), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .rd_data(rd_data), .ctrl_q(ctrl_q), .base_q(base_q),
        .unmapped_hit(unmapped_hit)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // 0 unmapped, 1 full, 2 upper half, 3 lower half, 4 flush
    function automatic int cls_of(input int a, input bit wide);
        if (a >= 32 || (a % 4) != 0) return 0;
        if (a / 8 == 2) return 4;
        if (a / 8 == 3) return 0;
        if ((a / 4) % 2 == 1) return 3;
        return wide ? 1 : 2;
    endfunction

    function automatic string tag_of(input int c, input bit write);
        case (c)
            1: return "R2";
            2: return write ? "R3" : "R5";
            3: return "R4";
            4: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic access(input int a, input bit wide, input bit write, input logic [63:0] wd);
        int c;
        string t;
        c = cls_of(a, wide);
        t = tag_of(c, write);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = write; acc_wide = wide;
        acc_addr = ADDR_W'(a); acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0;
        if (write) begin
            case (c)
                1: m_word[a/8] = wd;
                2: m_word[a/8][63:32] = wd[31:0];
                3: m_word[a/8][31:0] = wd[31:0];
                default: ;
            endcase
        end else begin
            case (c)
                1: m_rd = m_word[a/8];
                2: m_rd = {32'h0, m_word[a/8][63:32]};
                3: m_rd = {32'h0, m_word[a/8][31:0]};
                default: m_rd = 64'h0;
            endcase
        end
        chk({t, " ctrl"}, ctrl_q, m_word[0]);
        chk({t, " base"}, base_q, m_word[1]);
        chk({t, " rd_data (R8)"}, rd_data, m_rd);
        chk({t, " strobe"}, {63'h0, unmapped_hit}, {63'h0, c == 0});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        m_word[0] = '0; m_word[1] = '0; m_rd = '0;
        chk("R1 ctrl", ctrl_q, 64'h0);
        chk("R1 base", base_q, 64'h0);
        chk("R1 rd_data", rd_data, 64'h0);
        chk("R1 strobe", {63'h0, unmapped_hit}, 64'h0);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [63:0] held;
        do_reset();

        // Exhaustive sweep of every offset at both widths.
        for (int a = 0; a < 256; a++) begin
            for (int w = 0; w < 2; w++) begin
                access(a, w[0], 1'b1,
                       64'h0123_4567_89AB_CDEF ^ (64'(a) * 64'h0101_0101_0101_0101)
                       ^ (w[0] ? 64'hF0F0_F0F0_0F0F_0F0F : 64'h0));
                access(a, w[0], 1'b0, 64'h0);
            end
        end

        // R2 full write then R3 upper-half write keeps the low half
        access(8'h00, 1'b1, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD);
        access(8'h00, 1'b0, 1'b1, 64'h1111_2222_3333_4444);
        chk("R3 ctrl merge", ctrl_q, 64'h3333_4444_CCCC_DDDD);
        // R4 lower-half write on base keeps the high half
        access(8'h08, 1'b1, 1'b1, 64'h5555_6666_7777_8888);
        access(8'h0C, 1'b0, 1'b1, 64'h9999_AAAA_1234_5678);
        chk("R4 base merge", base_q, 64'h5555_6666_1234_5678);
        // R6 flush writes leave both words untouched
        access(8'h10, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        access(8'h14, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R6 ctrl untouched", ctrl_q, 64'h3333_4444_CCCC_DDDD);

        // R7 strobe lasts exactly one cycle
        access(8'h1A, 1'b0, 1'b0, 64'h0);
        @(negedge clk);
        chk("R7 strobe drops", {63'h0, unmapped_hit}, 64'h0);

        // R8 read data holds through idle cycles and writes
        access(8'h08, 1'b0, 1'b0, 64'h0);
        held = rd_data;
        chk("R8 upper read", held, 64'h0000_0000_5555_6666);
        repeat (2) @(negedge clk);
        access(8'h00, 1'b1, 1'b1, 64'h0);
        chk("R8 hold", rd_data, held);

        // R1 reset mid-run clears everything
        do_reset();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule